// File: doc/BRIEF.md
# Packed Integer-to-Float Conversion Unit

This block turns a vector of signed 32-bit integers into single-precision IEEE-754 values. Each lane is converted independently, and all lanes finish together. The vector holds up to sixteen 32-bit lanes. The active length is 4, 8 or 16 lanes.

An encoding-form input picks one of three behaviours:
- **Legacy form:** always 4 lanes. Destination bits above 128 keep their old contents.
- **Plain vector form:** 4 or 8 lanes. Bits above the active length are cleared.
- **Masked vector form:** 4, 8 or 16 lanes. Adds a per-lane write mask with merge or zeroing of unselected lanes, broadcast of one scalar to every lane, and a static rounding override that applies only at 16 lanes.

The unit is fed the old destination contents so that it can produce the full merged 512-bit result. An operation is accepted on a valid-in strobe. The converted vector is registered, and valid-out rises one cycle later with two flags: inexact and invalid-encoding.

Top module: `int2fp_vec_unit`

## Requirements
- R1: A lane whose source is a two's-complement integer of magnitude at most 2^24 converts exactly. Zero gives 0x00000000, 1 gives 0x3F800000 and -1 gives 0xBF800000.
- R2: Magnitudes above 2^24 are rounded to 24 significant bits. Rounding code 0 is nearest-even, 1 is toward minus infinity, 2 is toward plus infinity and 3 is toward zero. -2^31 always gives 0xCF000000.
- R3: Outside the legacy form, vlSel 0, 1 and 2 activate 4, 8 and 16 lanes, and every destination lane above the active length reads zero.
- R4: With encForm 0 (legacy), exactly lanes 0..3 are converted and written. Lanes 4..15 keep oldDest. vlSel, maskBits, bcastEn, zeroMask and rndOverride have no effect.
- R5: With encForm 2 and bcastEn set, scalarSrc is converted into every written lane and srcVec is ignored.
- R6: With encForm 2, an active lane whose maskBits bit is 0 keeps its oldDest value when zeroMask is 0.
- R7: With encForm 2, an active lane whose maskBits bit is 0 reads zero when zeroMask is 1. With encForm 1, maskBits is ignored and every active lane is written.
- R8: rndMode is used only when rndOverride is 1, encForm is 2 and vlSel is 2. In every other case nearest-even is used.
- R9: An operation is rejected in any of these cases:
  - encForm is 3;
  - specField differs from 4'b1111 in forms 1 or 2;
  - vlSel is 3 in forms 1 or 2;
  - vlSel is 2 in form 1.

  A rejected operation sets invalidOp, clears inexact and leaves destOut equal to oldDest.
- R10: inexact is 1 exactly when at least one written lane of an accepted operation lost precision. A masked-off lane never contributes.
- R11: After reset, outValid, destOut, inexact and invalidOp are zero. outValid is 1 exactly in the cycle after inValid. Results and flags hold while inValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| encForm | input | 2 | 0 legacy, 1 plain vector, 2 masked vector, 3 reserved |
| specField | input | 4 | Unused register-specifier field, must be 4'b1111 in forms 1 and 2 |
| vlSel | input | 2 | Active length: 0 = 4, 1 = 8, 2 = 16 lanes |
| maskBits | input | 16 | Per-lane write mask (form 2) |
| zeroMask | input | 1 | 1 zeroes unselected lanes, 0 merges |
| bcastEn | input | 1 | Broadcast scalarSrc to all lanes (form 2) |
| rndOverride | input | 1 | Enable static rounding override |
| rndMode | input | 2 | Override rounding code |
| scalarSrc | input | 32 | Broadcast source |
| srcVec | input | 512 | Source integer lanes, lane i at bits 32i+31:32i |
| oldDest | input | 512 | Previous destination contents |
| outValid | output | 1 | Result valid |
| destOut | output | 512 | Registered destination vector |
| inexact | output | 1 | Some written lane was rounded |
| invalidOp | output | 1 | Operation rejected |

## Verification
The hardest situation to reach is a rounding tie combined with a rounding override and masking: a lane must sit exactly halfway between two representable values while the form, length and override bits all select the non-default mode. The stimulus uses integers such as 2^24+1, 2^24+3 and 2^31-1. It first sets each of the four override codes in the 16-lane masked form, then repeats the same values in the 8-lane and plain forms to show that the override is dropped. A precision-losing value placed only in a masked-off lane, with exact values everywhere else, shows that a masked-off lane cannot raise inexact.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int LANE_W       = 32;
  localparam int MAX_LANES    = 16;
  localparam int LEGACY_LANES = 4;
  localparam int VEC_W        = LANE_W * MAX_LANES;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_PLAIN  = 2'd1,
    FORM_MASKED = 2'd2,
    FORM_RSVD   = 2'd3
  } formT;

  // strobes from control to datapath
  typedef struct packed {
    logic [MAX_LANES-1:0] laneEn;
    logic [MAX_LANES-1:0] writeEn;
    logic                 bcast;
    logic                 zeroUnsel;
    logic                 zeroUpper;
    logic [1:0]           rnd;
    logic                 reject;
  } strobeT;
endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
#(
  parameter int LANES = MAX_LANES
) (
  input  logic [1:0]       encForm,
  input  logic [3:0]       specField,
  input  logic [1:0]       vlSel,
  input  logic [LANES-1:0] maskBits,
  input  logic             zeroMask,
  input  logic             bcastEn,
  input  logic             rndOverride,
  input  logic [1:0]       rndMode,
  output strobeT           strb
);
  formT form;
  int   activeCnt;

  assign form = formT'(encForm);

  always_comb begin
    strb = '0;
    strb.reject = (form == FORM_RSVD)
               || ((form != FORM_LEGACY) && (specField != 4'b1111))
               || ((form != FORM_LEGACY) && (vlSel == 2'd3))
               || ((form == FORM_PLAIN)  && (vlSel == 2'd2));
    activeCnt = (form == FORM_LEGACY) ? LEGACY_LANES : (LEGACY_LANES << vlSel);
    for (int i = 0; i < LANES; i++) begin
      strb.laneEn[i] = (i < activeCnt);
    end
    strb.writeEn   = (form == FORM_MASKED) ? (strb.laneEn & maskBits) : strb.laneEn;
    strb.bcast     = (form == FORM_MASKED) && bcastEn;
    strb.zeroUnsel = (form == FORM_MASKED) && zeroMask;
    strb.zeroUpper = (form != FORM_LEGACY);
    strb.rnd       = ((form == FORM_MASKED) && (vlSel == 2'd2) && rndOverride) ? rndMode : 2'd0;
  end

  always_comb begin
    p_write_in_active_r3: assert ((strb.writeEn & ~strb.laneEn) == '0)
      else $error("write outside active lanes");
    if (form == FORM_LEGACY)
      p_legacy_four_r4: assert (strb.laneEn == LANES'(4'hF))
        else $error("legacy form must use four lanes");
  end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
  import cvt_pkg::*;
(
  input  logic [LANE_W-1:0] srcWord,
  input  logic [1:0]        rnd,
  output logic [LANE_W-1:0] fpWord,
  output logic              lossy
);
  logic        sgn;
  logic [31:0] mag;
  logic [31:0] norm;
  logic [4:0]  msbPos;
  logic        guardBit;
  logic        stickyBit;
  logic        roundUp;
  logic [24:0] mant25;
  logic [7:0]  expVal;

  always_comb begin
    sgn    = srcWord[31];
    mag    = sgn ? (~srcWord + 32'd1) : srcWord;
    msbPos = '0;
    for (int i = 0; i < 32; i++) begin
      if (mag[i]) msbPos = 5'(i);
    end
    norm      = mag << (5'd31 - msbPos);
    guardBit  = norm[7];
    stickyBit = |norm[6:0];
    lossy     = guardBit | stickyBit;
    case (rnd)
      2'd0:    roundUp = guardBit & (stickyBit | norm[8]);
      2'd1:    roundUp = lossy & sgn;
      2'd2:    roundUp = lossy & ~sgn;
      default: roundUp = 1'b0;
    endcase
    mant25 = {1'b0, norm[31:8]} + 25'(roundUp);
    expVal = 8'd127 + {3'b000, msbPos} + {7'd0, mant25[24]};
    if (mag == '0) fpWord = '0;
    else           fpWord = {sgn, expVal, mant25[24] ? 23'd0 : mant25[22:0]};
  end

  always_comb begin
    if (srcWord == '0)
      p_zero_pos_r1: assert (fpWord == '0 && !lossy) else $error("zero must give +0");
    if (srcWord == 32'h8000_0000)
      p_minint_r2: assert (fpWord == 32'hCF00_0000 && !lossy) else $error("min int");
  end
endmodule

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
#(
  parameter int LANES = MAX_LANES,
  parameter int LW    = LANE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  strobeT          strb,
  input  logic [LW-1:0]   scalarSrc,
  input  logic [LANES*LW-1:0] srcVec,
  input  logic [LANES*LW-1:0] oldDest,
  output logic            outValid,
  output logic [LANES*LW-1:0] destOut,
  output logic            inexact,
  output logic            invalidOp
);
  logic [LANES*LW-1:0] nextDest;
  logic [LANES-1:0]    lossyHit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] srcW, fpW, oldW;
    logic          lossyL;
    assign srcW = strb.bcast ? scalarSrc : srcVec[g*LW +: LW];
    assign oldW = oldDest[g*LW +: LW];
    i2f_lane u_lane (.srcWord(srcW), .rnd(strb.rnd), .fpWord(fpW), .lossy(lossyL));
    always_comb begin
      if (strb.reject)            nextDest[g*LW +: LW] = oldW;
      else if (strb.writeEn[g])   nextDest[g*LW +: LW] = fpW;
      else if (strb.laneEn[g])    nextDest[g*LW +: LW] = strb.zeroUnsel ? '0 : oldW;
      else                        nextDest[g*LW +: LW] = strb.zeroUpper ? '0 : oldW;
    end
    assign lossyHit[g] = lossyL & strb.writeEn[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      destOut   <= '0;
      inexact   <= 1'b0;
      invalidOp <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        destOut   <= nextDest;
        inexact   <= (|lossyHit) & ~strb.reject;
        invalidOp <= strb.reject;
      end
    end
  end

  p_reject_no_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidOp) |-> !inexact);
  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(destOut) && $stable(inexact) && $stable(invalidOp));
endmodule

// File: rtl/int2fp_vec_unit.sv
module int2fp_vec_unit
  import cvt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           encForm,
  input  logic [3:0]           specField,
  input  logic [1:0]           vlSel,
  input  logic [MAX_LANES-1:0] maskBits,
  input  logic                 zeroMask,
  input  logic                 bcastEn,
  input  logic                 rndOverride,
  input  logic [1:0]           rndMode,
  input  logic [LANE_W-1:0]    scalarSrc,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [VEC_W-1:0]     oldDest,
  output logic                 outValid,
  output logic [VEC_W-1:0]     destOut,
  output logic                 inexact,
  output logic                 invalidOp
);
  localparam int LEG_W = LEGACY_LANES * LANE_W;

  strobeT strb;

  cvt_ctrl #(.LANES(MAX_LANES)) u_ctrl (
    .encForm(encForm), .specField(specField), .vlSel(vlSel), .maskBits(maskBits),
    .zeroMask(zeroMask), .bcastEn(bcastEn), .rndOverride(rndOverride),
    .rndMode(rndMode), .strb(strb)
  );

  cvt_datapath #(.LANES(MAX_LANES), .LW(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .scalarSrc(scalarSrc),
    .srcVec(srcVec), .oldDest(oldDest), .outValid(outValid), .destOut(destOut),
    .inexact(inexact), .invalidOp(invalidOp)
  );

  p_valid_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_reject_keeps_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encForm == 2'd3) |=> (invalidOp && destOut == $past(oldDest)));
  p_legacy_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encForm == 2'd0) |=> (destOut[VEC_W-1:LEG_W] == $past(oldDest[VEC_W-1:LEG_W])));
endmodule

// File: tb/int2fp_vec_unit_bench.sv
`timescale 1ns/1ps
module int2fp_vec_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   encForm = '0;
  logic [3:0]   specField = 4'hF;
  logic [1:0]   vlSel = '0;
  logic [15:0]  maskBits = '1;
  logic         zeroMask = 1'b0;
  logic         bcastEn = 1'b0;
  logic         rndOverride = 1'b0;
  logic [1:0]   rndMode = '0;
  logic [31:0]  scalarSrc = '0;
  logic [511:0] srcVec = '0;
  logic [511:0] oldDest = '0;
  logic         outValid;
  logic [511:0] destOut;
  logic         inexact;
  logic         invalidOp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int2fp_vec_unit u_int2fp_vec_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .encForm(encForm), .specField(specField),
    .vlSel(vlSel), .maskBits(maskBits), .zeroMask(zeroMask), .bcastEn(bcastEn),
    .rndOverride(rndOverride), .rndMode(rndMode), .scalarSrc(scalarSrc), .srcVec(srcVec),
    .oldDest(oldDest), .outValid(outValid), .destOut(destOut), .inexact(inexact),
    .invalidOp(invalidOp)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference conversion by divide-and-remainder
  task automatic refCvt(input logic [31:0] x, input logic [1:0] rm,
                        output logic [31:0] f, output logic inx);
    longint m, q, r, half;
    int s, e;
    logic sgn, up;
    sgn = x[31];
    m = longint'($signed(x));
    if (m < 0) m = -m;
    inx = 1'b0;
    if (m == 0) begin f = '0; return; end
    s = 0;
    while ((m >> s) >= (64'd1 << 24)) s++;
    q = m >> s;
    r = m - (q << s);
    half = (s > 0) ? (64'd1 << (s - 1)) : 0;
    inx = (r != 0);
    case (rm)
      2'd0: up = (s > 0) && ((r > half) || (r == half && q[0]));
      2'd1: up = inx && sgn;
      2'd2: up = inx && !sgn;
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (q == (64'd1 << 24)) begin q = q >> 1; s++; end
    e = 150 + s;
    while (q < (64'd1 << 23)) begin q = q << 1; e--; end
    f = {sgn, 8'(e), q[22:0]};
  endtask

  // drive one operation, compute expected result, compare
  task automatic runOp(input string tag);
    logic [511:0] expD;
    logic expInx, expRej, wr, act, li;
    logic [31:0] fv, src;
    int cnt;
    logic [1:0] rm;
    expRej = (encForm == 2'd3) || (encForm != 2'd0 && specField != 4'hF)
          || (encForm != 2'd0 && vlSel == 2'd3) || (encForm == 2'd1 && vlSel == 2'd2);
    cnt = (encForm == 2'd0) ? 4 : (4 << vlSel);
    rm = (encForm == 2'd2 && vlSel == 2'd2 && rndOverride) ? rndMode : 2'd0;
    expInx = 1'b0;
    for (int i = 0; i < 16; i++) begin
      act = (i < cnt);
      wr  = act && (encForm != 2'd2 || maskBits[i]);
      src = (encForm == 2'd2 && bcastEn) ? scalarSrc : srcVec[i*32 +: 32];
      if (expRej) expD[i*32 +: 32] = oldDest[i*32 +: 32];
      else if (wr) begin
        refCvt(src, rm, fv, li);
        expD[i*32 +: 32] = fv;
        expInx |= li;
      end else if (act)
        expD[i*32 +: 32] = (encForm == 2'd2 && zeroMask) ? '0 : oldDest[i*32 +: 32];
      else
        expD[i*32 +: 32] = (encForm == 2'd0) ? oldDest[i*32 +: 32] : '0;
    end
    if (expRej) expInx = 1'b0;
    @(negedge clk);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid"}, 512'(outValid), 512'(1'b1));
    check({tag, " destOut"}, destOut, expD);
    check({tag, " inexact"}, 512'(inexact), 512'(expInx));
    check({tag, " invalidOp"}, 512'(invalidOp), 512'(expRej));
  endtask

  task automatic setForm(input logic [1:0] f, input logic [1:0] v);
    encForm = f; vlSel = v; specField = 4'hF; maskBits = '1; zeroMask = 0;
    bcastEn = 0; rndOverride = 0; rndMode = 0;
  endtask

  task automatic fillSrc(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) begin
      srcVec[i*32 +: 32] = (32'(i) * 32'h9E37_79B9) ^ seed;
      oldDest[i*32 +: 32] = 32'hA5A5_0000 | 32'(i);
    end
  endtask

  task automatic testReset();
    check("R11 reset outValid", 512'(outValid), '0);
    check("R11 reset destOut", destOut, '0);
    check("R11 reset flags", 512'({inexact, invalidOp}), '0);
  endtask

  task automatic testExact();
    setForm(2'd1, 2'd1);
    fillSrc(32'h0);
    srcVec[31:0] = 32'd0; srcVec[63:32] = 32'hFFFF_FFFF; srcVec[95:64] = 32'd1;
    srcVec[127:96] = 32'h0100_0000; srcVec[159:128] = 32'hFF00_0000;
    srcVec[191:160] = 32'd12345; srcVec[223:192] = -32'd777; srcVec[255:224] = 32'h00FF_FFFF;
    runOp("R1 exact small ints");
    check("R1 zero lane", 512'(destOut[31:0]), 512'(32'h0));
    check("R1 minus one", 512'(destOut[63:32]), 512'(32'hBF80_0000));
    check("R1 plus one", 512'(destOut[95:64]), 512'(32'h3F80_0000));
  endtask

  task automatic testRounding();
    for (int m = 0; m < 4; m++) begin
      setForm(2'd2, 2'd2);
      rndOverride = 1; rndMode = 2'(m);
      fillSrc(32'h1234_5678 + 32'(m));
      srcVec[31:0] = 32'h0100_0001; srcVec[63:32] = 32'h0100_0003;
      srcVec[95:64] = 32'h7FFF_FFFF; srcVec[127:96] = 32'h8000_0000;
      srcVec[159:128] = -32'h0100_0001; srcVec[191:160] = -32'h0100_0003;
      runOp("R2 rounding mode");
      check("R2 min int exact", 512'(destOut[127:96]), 512'(32'hCF00_0000));
    end
    check("R2 max int toward zero", 512'(destOut[95:64]), 512'(32'h4EFF_FFFF));
  endtask

  task automatic testLength();
    for (int v = 0; v < 2; v++) begin
      setForm(2'd2, 2'(v));
      fillSrc(32'hCAFE_0000 + 32'(v));
      runOp("R3 active length upper zero");
    end
    setForm(2'd1, 2'd0);
    fillSrc(32'h0BAD_F00D);
    runOp("R3 plain form four lanes");
    check("R3 lane4 cleared", 512'(destOut[159:128]), '0);
  endtask

  task automatic testLegacy();
    setForm(2'd0, 2'd2);
    maskBits = 16'h0; bcastEn = 1; zeroMask = 1; rndOverride = 1; rndMode = 2'd3;
    specField = 4'h0;
    scalarSrc = 32'd5;
    fillSrc(32'h7777_0001);
    runOp("R4 legacy form");
    check("R4 upper kept", destOut[511:128], oldDest[511:128]);
  endtask

  task automatic testBcast();
    setForm(2'd2, 2'd1);
    bcastEn = 1; scalarSrc = 32'hFFFF_FFFE; maskBits = 16'h00F3;
    fillSrc(32'h5555_AAAA);
    runOp("R5 broadcast");
    check("R5 lane7 value", 512'(destOut[255:224]), 512'(32'hC000_0000));
  endtask

  task automatic testMask();
    setForm(2'd2, 2'd2);
    maskBits = 16'hA5C3;
    fillSrc(32'h0F0F_1234);
    runOp("R6 merge masking");
    check("R6 lane2 merged", 512'(destOut[95:64]), 512'(oldDest[95:64]));
    zeroMask = 1;
    runOp("R7 zero masking");
    check("R7 lane2 zeroed", 512'(destOut[95:64]), '0);
    setForm(2'd1, 2'd1);
    maskBits = 16'h0; zeroMask = 1;
    runOp("R7 plain form ignores mask");
  endtask

  task automatic testOverride();
    setForm(2'd2, 2'd1);
    rndOverride = 1; rndMode = 2'd3;
    fillSrc(32'h0);
    srcVec[31:0] = 32'h7FFF_FFFF; srcVec[63:32] = 32'h0100_0003;
    runOp("R8 override dropped at 8 lanes");
    check("R8 nearest used", 512'(destOut[31:0]), 512'(32'h4F00_0000));
    setForm(2'd2, 2'd2);
    rndOverride = 0; rndMode = 2'd2;
    srcVec[31:0] = 32'h0100_0001;
    runOp("R8 override disabled");
    check("R8 tie to even", 512'(destOut[31:0]), 512'(32'h4B80_0000));
  endtask

  task automatic testReject();
    setForm(2'd2, 2'd2); specField = 4'hE; fillSrc(32'h3333_0000);
    runOp("R9 bad specifier");
    setForm(2'd3, 2'd0); fillSrc(32'h4444_0000);
    runOp("R9 reserved form");
    setForm(2'd2, 2'd3); srcVec[31:0] = 32'h0100_0001;
    runOp("R9 bad length");
    setForm(2'd1, 2'd2);
    runOp("R9 plain form 16 lanes");
    check("R9 dest unchanged", destOut, oldDest);
  endtask

  task automatic testInexact();
    setForm(2'd2, 2'd0);
    srcVec = '0; oldDest = '0;
    srcVec[31:0] = 32'd3; srcVec[63:32] = 32'h0100_0001; srcVec[95:64] = 32'd9;
    maskBits = 16'hFFFD;
    runOp("R10 masked lossy lane");
    check("R10 inexact clear", 512'(inexact), '0);
    maskBits = 16'hFFFF;
    runOp("R10 unmasked lossy lane");
    check("R10 inexact set", 512'(inexact), 512'(1'b1));
  endtask

  task automatic testHold();
    logic [511:0] snap;
    logic [1:0] flags;
    setForm(2'd2, 2'd2); fillSrc(32'h1357_9BDF);
    runOp("R11 op before hold");
    snap = destOut; flags = {inexact, invalidOp};
    fillSrc(32'h2468_ACE0); encForm = 2'd3;
    @(negedge clk); @(negedge clk);
    check("R11 idle outValid", 512'(outValid), '0);
    check("R11 idle dest held", destOut, snap);
    check("R11 idle flags held", 512'({inexact, invalidOp}), 512'(flags));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExact();
    testRounding();
    testLength();
    testLegacy();
    testBcast();
    testMask();
    testOverride();
    testReject();
    testInexact();
    testHold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule